// File: doc/BRIEF.md
# Two-Class Vectored Interrupt Controller

This block collects eleven peripheral request lines and steers each one either to a normal interrupt output or to a fast interrupt output. Software controls it through a word-indexed 32-bit register port. Any single enable can be set or cleared atomically by writing a source number to one of two number registers. The whole enable word can also be saved, zeroed and restored in one access each. A force register lets software raise any request without the peripheral.

For each class the block shows a pending view and a vector register. The vector holds the number of the highest-numbered pending source in that class. A per-class disable bit in the control register silences each output. The normal class also has a mask level: normal sources numbered below it are left out of the vector and the normal output. The request lines are sampled into a register. The two interrupt outputs are registered, and a read returns its word in the cycle after it is requested.

Top module: `irq_two_class_ctrl`

## Requirements
- R1: After reset the control, mask level, enable, type and force registers are all zero. Both vectors read 0x1F and both interrupt outputs are low.
- R2: Bit n of every per-source register belongs to source n (0 to 10), and bits 31:11 read zero. The registers sit at these word indexes: 0 control, 1 mask level, 2 set-enable-by-number, 3 clear-enable-by-number, 4 enable, 5 type, 10 normal vector, 11 fast vector, 12 raw source, 13 force, 14 normal pending, 15 fast pending.
- R3: Writing a value v below 11 to index 2 sets enable bit v and leaves every other enable bit unchanged.
- R4: Writing a value v below 11 to index 3 clears enable bit v and leaves every other enable bit unchanged.
- R5: A value of 11 or more written to index 2 or 3 changes nothing. Both number registers read zero.
- R6: A write to index 4 replaces the whole enable word. Writing zero disables all sources, and writing a saved value back restores it.
- R7: The effective request is (sampled source OR force) AND enable. Normal pending is the effective request with type bit 0. Fast pending is the effective request with type bit 1.
- R8: Each vector reads the highest-numbered pending source of its class, or 0x1F when there is none. A normal source counts only when its number is at least the mask level (bits 4:0 of index 1).
- R9: The normal output is high when a normal source that passes the mask level is pending and control bit 20 is 0. It follows a change in the registers one clock later, and a change on the request lines two clocks later.
- R10: The fast output is high when any fast source is pending and control bit 19 is 0, with the same latency as R9. Control reads back only bits 20 and 19.
- R11: Writes to indexes 6 to 12, 14 and 15 are ignored. Indexes 6 to 9 read zero.
- R12: A read requested with rd_en at a clock edge puts the addressed word on rd_data after that edge. rd_data holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Word index of write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | 4 | Word index of read |
| rd_data | output | 32 | Registered read data |
| src_in | input | 11 | Peripheral request lines |
| irq_normal | output | 1 | Normal-class interrupt |
| irq_fast | output | 1 | Fast-class interrupt |

## Verification
The hardest case to reach is one where both classes hold pending sources at once and the mask level splits the normal class. Here the normal vector must skip a source that is still shown in normal pending, while the fast vector names a different source. The stimulus gets there by enabling two sources through the number registers and driving both lines. It then moves the higher source to the fast class with the type register and steps the mask level across the lower source. After each step the bench reads both pending words and both vectors, and samples the two outputs at the cycle the latency rule gives.

// File: rtl/ic_pkg.sv
package ic_pkg;
  typedef enum logic [3:0] {
    IX_CTRL   = 4'd0,
    IX_LEVEL  = 4'd1,
    IX_SETNUM = 4'd2,
    IX_CLRNUM = 4'd3,
    IX_ENABLE = 4'd4,
    IX_CLASS  = 4'd5,
    IX_NVEC   = 4'd10,
    IX_FVEC   = 4'd11,
    IX_RAW    = 4'd12,
    IX_FORCE  = 4'd13,
    IX_NPEND  = 4'd14,
    IX_FPEND  = 4'd15
  } ic_idx_e;
endpackage

// File: rtl/ic_prio_enc.sv
module ic_prio_enc #(
  parameter int N = 11,
  parameter int W = 5
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] num
);
  // highest index wins; all-ones when nothing requests
  always_comb begin
    num = '1;
    for (int i = 0; i < N; i++) begin
      if (req[i]) num = W'(i);
    end
  end
endmodule

// File: rtl/ic_regs.sv
module ic_regs
  import ic_pkg::*;
#(
  parameter int NSRC     = 11,
  parameter int DW       = 32,
  parameter int IW       = 4,
  parameter int VW       = 5,
  parameter int NDIS_BIT = 20,
  parameter int FDIS_BIT = 19
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_data,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] class_q,
  output logic [NSRC-1:0] force_q,
  output logic [VW-1:0]   level_q,
  output logic            ndis_q,
  output logic            fdis_q
);
  logic [NSRC-1:0] num_hit;
  logic wr_ctrl, wr_level, wr_set, wr_clr, wr_en_word, wr_class, wr_force;

  assign wr_ctrl    = wr_en && (wr_idx == IW'(IX_CTRL));
  assign wr_level   = wr_en && (wr_idx == IW'(IX_LEVEL));
  assign wr_set     = wr_en && (wr_idx == IW'(IX_SETNUM));
  assign wr_clr     = wr_en && (wr_idx == IW'(IX_CLRNUM));
  assign wr_en_word = wr_en && (wr_idx == IW'(IX_ENABLE));
  assign wr_class   = wr_en && (wr_idx == IW'(IX_CLASS));
  assign wr_force   = wr_en && (wr_idx == IW'(IX_FORCE));

  // full-width compare: out-of-range numbers hit no bit
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_hit
      assign num_hit[g] = (wr_data == DW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      class_q <= '0;
      force_q <= '0;
      level_q <= '0;
      ndis_q  <= 1'b0;
      fdis_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ndis_q <= wr_data[NDIS_BIT];
        fdis_q <= wr_data[FDIS_BIT];
      end
      if (wr_level) level_q <= wr_data[VW-1:0];
      if (wr_en_word)  en_q <= wr_data[NSRC-1:0];
      else if (wr_set) en_q <= en_q | num_hit;
      else if (wr_clr) en_q <= en_q & ~num_hit;
      if (wr_class) class_q <= wr_data[NSRC-1:0];
      if (wr_force) force_q <= wr_data[NSRC-1:0];
    end
  end
endmodule

// File: rtl/ic_readmux.sv
module ic_readmux
  import ic_pkg::*;
#(
  parameter int NSRC     = 11,
  parameter int DW       = 32,
  parameter int IW       = 4,
  parameter int VW       = 5,
  parameter int NDIS_BIT = 20,
  parameter int FDIS_BIT = 19
) (
  input  logic [IW-1:0]   idx,
  input  logic            ndis,
  input  logic            fdis,
  input  logic [VW-1:0]   level,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] cls,
  input  logic [VW-1:0]   nvec,
  input  logic [VW-1:0]   fvec,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] frc,
  input  logic [NSRC-1:0] npend,
  input  logic [NSRC-1:0] fpend,
  output logic [DW-1:0]   word
);
  localparam int PADS = DW - NSRC;
  localparam int PADV = DW - VW;

  always_comb begin
    word = '0;
    case (idx)
      IW'(IX_CTRL): begin
        word[NDIS_BIT] = ndis;
        word[FDIS_BIT] = fdis;
      end
      IW'(IX_LEVEL):  word = {{PADV{1'b0}}, level};
      IW'(IX_ENABLE): word = {{PADS{1'b0}}, en};
      IW'(IX_CLASS):  word = {{PADS{1'b0}}, cls};
      IW'(IX_NVEC):   word = {{PADV{1'b0}}, nvec};
      IW'(IX_FVEC):   word = {{PADV{1'b0}}, fvec};
      IW'(IX_RAW):    word = {{PADS{1'b0}}, raw};
      IW'(IX_FORCE):  word = {{PADS{1'b0}}, frc};
      IW'(IX_NPEND):  word = {{PADS{1'b0}}, npend};
      IW'(IX_FPEND):  word = {{PADS{1'b0}}, fpend};
      default:        word = '0;
    endcase
  end
endmodule

// File: rtl/irq_two_class_ctrl.sv
module irq_two_class_ctrl
  import ic_pkg::*;
#(
  parameter int NSRC     = 11,
  parameter int DW       = 32,
  parameter int IW       = 4,
  parameter int VW       = 5,
  parameter int NDIS_BIT = 20,
  parameter int FDIS_BIT = 19
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  input  logic [IW-1:0]   rd_idx,
  output logic [DW-1:0]   rd_data,
  input  logic [NSRC-1:0] src_in,
  output logic            irq_normal,
  output logic            irq_fast
);
  logic [NSRC-1:0] en_q, class_q, force_q, raw_q;
  logic [NSRC-1:0] eff, npend, fpend, nqual;
  logic [VW-1:0]   level_q, nvec, fvec;
  logic            ndis_q, fdis_q;
  logic [DW-1:0]   rd_word;

  ic_regs #(
    .NSRC(NSRC), .DW(DW), .IW(IW), .VW(VW),
    .NDIS_BIT(NDIS_BIT), .FDIS_BIT(FDIS_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .en_q(en_q), .class_q(class_q), .force_q(force_q), .level_q(level_q),
    .ndis_q(ndis_q), .fdis_q(fdis_q)
  );

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= src_in;
  end

  assign eff   = (raw_q | force_q) & en_q;
  assign npend = eff & ~class_q;
  assign fpend = eff & class_q;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_lvl
      assign nqual[g] = npend[g] && (VW'(g) >= level_q);
    end
  endgenerate

  ic_prio_enc #(.N(NSRC), .W(VW)) u_nenc (.req(nqual), .num(nvec));
  ic_prio_enc #(.N(NSRC), .W(VW)) u_fenc (.req(fpend), .num(fvec));

  ic_readmux #(
    .NSRC(NSRC), .DW(DW), .IW(IW), .VW(VW),
    .NDIS_BIT(NDIS_BIT), .FDIS_BIT(FDIS_BIT)
  ) u_rmux (
    .idx(rd_idx), .ndis(ndis_q), .fdis(fdis_q), .level(level_q),
    .en(en_q), .cls(class_q), .nvec(nvec), .fvec(fvec), .raw(raw_q),
    .frc(force_q), .npend(npend), .fpend(fpend), .word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      irq_normal <= 1'b0;
      irq_fast   <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_word;
      irq_normal <= (|nqual) && !ndis_q;
      irq_fast   <= (|fpend) && !fdis_q;
    end
  end
endmodule

// File: rtl/ic_checker.sv
module ic_checker #(
  parameter int NSRC = 11,
  parameter int DW   = 32,
  parameter int IW   = 4,
  parameter int VW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [IW-1:0]   wr_idx,
  input logic [DW-1:0]   wr_data,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] fpend,
  input logic            ndis_q,
  input logic            fdis_q,
  input logic [VW-1:0]   nvec,
  input logic [VW-1:0]   fvec,
  input logic            irq_normal,
  input logic            irq_fast
);
  logic [NSRC-1:0] onehot;
  assign onehot = (wr_data < DW'(NSRC)) ? (NSRC'(1) << wr_data[3:0]) : '0;

  assert_setnum_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IW'(2) && wr_data < DW'(NSRC))
      |=> (en_q == ($past(en_q) | $past(onehot))));

  assert_clrnum_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IW'(3) && wr_data < DW'(NSRC))
      |=> (en_q == ($past(en_q) & ~$past(onehot))));

  assert_badnum_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == IW'(2) || wr_idx == IW'(3)) && wr_data >= DW'(NSRC))
      |=> $stable(en_q));

  assert_ndis_R9: assert property (@(posedge clk) disable iff (rst)
    ndis_q |=> !irq_normal);

  assert_fdis_R10: assert property (@(posedge clk) disable iff (rst)
    fdis_q |=> !irq_fast);

  assert_fast_src_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_fast) |-> $past(|fpend));

  assert_vec_range_R8: assert property (@(posedge clk) disable iff (rst)
    ((nvec == '1 || nvec < VW'(NSRC)) && (fvec == '1 || fvec < VW'(NSRC))));
endmodule

bind irq_two_class_ctrl ic_checker #(
  .NSRC(NSRC), .DW(DW), .IW(IW), .VW(VW)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .en_q(en_q), .fpend(fpend), .ndis_q(ndis_q), .fdis_q(fdis_q),
  .nvec(nvec), .fvec(fvec), .irq_normal(irq_normal), .irq_fast(irq_fast)
);

// File: tb/irq_two_class_ctrl_test.sv
module irq_two_class_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [10:0] src_in = '0;
  logic        irq_normal, irq_fast;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb[$];
  logic rd_issued = 1'b0;

  always #2 clk = ~clk;

  irq_two_class_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .src_in(src_in),
    .irq_normal(irq_normal), .irq_fast(irq_fast)
  );

  always @(posedge clk) rd_issued <= rd_en;

  // monitor: pops expected words once the registered read data is out
  always @(negedge clk) begin
    if (rd_issued && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (rd_data !== e.exp) begin
        failures++;
        $display("FAIL %s: actual=%h expected=%h", e.tag, rd_data, e.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [31:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    rd_en = 1'b1; rd_idx = idx;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic irq_chk(input logic en, input logic ef, input string tag);
    repeat (2) @(negedge clk);
    checks++;
    if (irq_normal !== en || irq_fast !== ef) begin
      failures++;
      $display("FAIL %s: actual n=%b f=%b expected n=%b f=%b",
               tag, irq_normal, irq_fast, en, ef);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    irq_chk(1'b0, 1'b0, "R1 reset outputs");
    rd(4'd0,  32'h0,  "R1 ctrl reset");
    rd(4'd4,  32'h0,  "R1 enable reset");
    rd(4'd10, 32'h1F, "R1 normal vector reset");
    rd(4'd11, 32'h1F, "R1 fast vector reset");
    // R3 set by number
    wr(4'd2, 32'd3);
    wr(4'd2, 32'd7);
    rd(4'd4, 32'h88, "R3 set bits 3 and 7");
    // R5 out of range and readback
    wr(4'd2, 32'd11);
    wr(4'd2, 32'h100);
    rd(4'd4, 32'h88, "R5 setnum 11 ignored");
    rd(4'd2, 32'h0,  "R5 setnum reads zero");
    // R4 clear by number
    wr(4'd3, 32'd3);
    rd(4'd4, 32'h80, "R4 clear bit 3");
    wr(4'd3, 32'd15);
    rd(4'd4, 32'h80, "R5 clrnum 15 ignored");
    rd(4'd3, 32'h0,  "R5 clrnum reads zero");
    // R6 / R2 whole word
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, 32'h7FF, "R2 upper enable bits read zero");
    wr(4'd4, 32'h0);
    rd(4'd4, 32'h0,   "R6 zero disables all");
    wr(4'd4, 32'h88);
    rd(4'd4, 32'h88,  "R6 restore saved");
    // R7 / R8 / R9 normal class
    @(negedge clk); src_in = 11'h088;
    irq_chk(1'b1, 1'b0, "R9 normal output raised");
    rd(4'd12, 32'h88, "R2 raw source");
    rd(4'd14, 32'h88, "R7 normal pending");
    rd(4'd10, 32'd7,  "R8 normal vector highest");
    // R8 mask level
    wr(4'd1, 32'd8);
    rd(4'd10, 32'h1F, "R8 level 8 hides both");
    rd(4'd14, 32'h88, "R7 pending unaffected by level");
    irq_chk(1'b0, 1'b0, "R9 normal masked by level");
    wr(4'd1, 32'd3);
    rd(4'd10, 32'd7,  "R8 level 3 vector");
    wr(4'd1, 32'd0);
    // R7 / R10 fast class
    wr(4'd5, 32'h80);
    rd(4'd15, 32'h80, "R7 fast pending");
    rd(4'd14, 32'h08, "R7 normal pending split");
    rd(4'd11, 32'd7,  "R8 fast vector");
    rd(4'd10, 32'd3,  "R8 normal vector after split");
    irq_chk(1'b1, 1'b1, "R10 both outputs");
    wr(4'd1, 32'd4);
    irq_chk(1'b0, 1'b1, "R9 level over lone normal source");
    wr(4'd1, 32'd0);
    // control disables
    wr(4'd0, 32'h0010_0000);
    irq_chk(1'b0, 1'b1, "R9 normal disable");
    rd(4'd0, 32'h0010_0000, "R10 ctrl readback bit 20");
    wr(4'd0, 32'hFFFF_FFFF);
    irq_chk(1'b0, 1'b0, "R10 fast disable");
    rd(4'd0, 32'h0018_0000, "R10 ctrl only two bits");
    wr(4'd0, 32'h0);
    irq_chk(1'b1, 1'b1, "R10 disables cleared");
    // force
    @(negedge clk); src_in = '0;
    wr(4'd5, 32'h0);
    wr(4'd13, 32'h400);
    wr(4'd2, 32'd10);
    rd(4'd13, 32'h400, "R7 force readback");
    rd(4'd14, 32'h400, "R7 forced pending");
    rd(4'd10, 32'd10,  "R8 forced vector");
    irq_chk(1'b1, 1'b0, "R9 forced normal");
    // R11 read-only and reserved
    wr(4'd14, 32'h0);
    wr(4'd12, 32'h7FF);
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd14, 32'h400, "R11 pending write ignored");
    rd(4'd12, 32'h0,   "R11 raw write ignored");
    rd(4'd7,  32'h0,   "R11 reserved reads zero");
    // R12 hold between reads
    repeat (3) @(negedge clk);
    checks++;
    if (rd_data !== 32'h0) begin
      failures++;
      $display("FAIL R12 hold: actual=%h expected=%h", rd_data, 32'h0);
    end
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule